// File: doc/BRIEF.md
# Prioritized Maskable Interrupt Controller

The controller collects eight maskable interrupt request lines and one non-maskable line. It latches each request on its rising edge and holds it as pending. It then filters the pending maskable requests by a per-line enable, a minimum-priority threshold and a global enable. The highest-priority survivor is presented to the processor as a single interrupt line together with a vector index. Line 0 has the highest priority, and the non-maskable line always outranks every maskable line.

When the processor acknowledges, the presented request leaves the pending set and enters the in-service set. Optionally, the global enable is cleared in the same step, so that software must turn interrupts back on before any nesting can happen. An end-of-service input retires one in-service entry. A maskable request is only presented when it ranks above every routine that is still in service. This lets a higher-priority request preempt a running lower-priority routine, while a lower-priority request waits.

Requests that arrive while they cannot be presented stay pending. They are served in priority order as soon as the blocking condition is removed. Software sets the line enables, the threshold and the global controls through a small write-only register port.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, `irq_out` is 0 and `irq_vec` is 0. Nothing is pending or in service, every line enable is 0, the threshold is 0, the global enable is 0 and auto-disable-on-entry is 1.
- R2: A request is latched as pending only on a 0-to-1 transition of its input. A line held high after its request has been acknowledged does not request again.
- R3: Among the eligible pending maskable lines, the lowest index wins, and `irq_vec` equals that index.
- R4: A write with `cfg_sel`=0 loads the line enables, where bit i=1 enables line i. A disabled line's request stays pending and is presented once the line is enabled.
- R5: A write with `cfg_sel`=1 loads the threshold T from `cfg_data[3:0]`. Line i is eligible only when 7-i >= T. With T=8, no maskable line is eligible.
- R6: A write with `cfg_sel`=2 sets the global enable from bit 0 and auto-disable from bit 1. While the global enable is 0, no maskable line is presented. Requests raised in that time are served later, in priority order.
- R7: When `irq_ack` is high while `irq_out` is high, the presented request is cleared from pending and set in service. If auto-disable is 1, the global enable is cleared, unless a control write in the same cycle sets it.
- R8: A maskable line is presented only if no line of equal or higher priority is in service, and only if the non-maskable routine is not in service. When `eos_valid` is high, the in-service entry `eos_vec` is cleared.
- R9: The non-maskable line uses vector 8. It is presented whenever it is pending and not in service, regardless of enables, threshold and global enable, and it takes precedence over all maskable lines. A new edge arriving while it is in service waits until its end of service.
- R10: An `irq_ack` while `irq_out` is 0 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | 8 | Maskable request lines, rising-edge sensitive |
| nmi_req | input | 1 | Non-maskable request line, rising-edge sensitive |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 enables, 1 threshold, 2 control |
| cfg_data | input | 8 | Register write data |
| irq_ack | input | 1 | Processor acknowledge of the presented request |
| eos_valid | input | 1 | End-of-service strobe |
| eos_vec | input | 4 | Vector whose routine has ended (8 for non-maskable) |
| irq_out | output | 1 | Interrupt to the processor |
| irq_vec | output | 4 | Vector index of the presented request, 0 when idle |

## Verification
Simultaneous requests on two lines show whether the priority encoder picks the right winner. Requests raised on different cycles while the global enable is off show whether deferred entries are served in order rather than in order of arrival. Acknowledging with auto-disable on and then off, and raising a higher and a lower line against a routine already in service, separates preemption from waiting. Threshold values at the boundary, a disabled line, a held-high line after its acknowledge and a non-maskable edge during every blocking condition show that each filter acts alone and that the non-maskable path bypasses them all.

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int NUM_LINES = 8,
  localparam int IDX_W = $clog2(NUM_LINES),
  localparam int VEC_W = $clog2(NUM_LINES + 1),
  localparam int TH_W  = $clog2(NUM_LINES + 1),
  localparam int PW    = NUM_LINES + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irq_req,
  input  logic                 nmi_req,
  input  logic                 cfg_we,
  input  logic [1:0]           cfg_sel,
  input  logic [NUM_LINES-1:0] cfg_data,
  input  logic                 irq_ack,
  input  logic                 eos_valid,
  input  logic [VEC_W-1:0]     eos_vec,
  output logic                 irq_out,
  output logic [VEC_W-1:0]     irq_vec
);

  localparam logic [VEC_W-1:0] NMI_VEC = VEC_W'(NUM_LINES);

  logic [NUM_LINES-1:0] req_q, line_en;
  logic                 nmi_q;
  logic [PW-1:0]        pend, svc;
  logic [TH_W-1:0]      thr;
  logic                 gie, auto_off;

  logic [NUM_LINES-1:0] elig, blocked, cand;
  logic [IDX_W-1:0]     win_idx;
  logic                 nmi_sel, take;
  logic [PW-1:0]        rise, ack_hot, eos_hot;

  always_comb begin
    logic run;
    run = 1'b0;
    for (int i = 0; i < NUM_LINES; i++) begin
      run        = run | svc[i];
      blocked[i] = run;
      elig[i]    = pend[i] & line_en[i] & (thr <= TH_W'(NUM_LINES - 1 - i));
    end
  end

  assign cand = elig & ~blocked & {NUM_LINES{gie & ~svc[NUM_LINES]}};

  always_comb begin
    win_idx = '0;
    for (int i = NUM_LINES - 1; i >= 0; i--)
      if (cand[i]) win_idx = IDX_W'(i);
  end

  assign nmi_sel = pend[NUM_LINES] & ~svc[NUM_LINES];
  assign irq_out = nmi_sel | (|cand);
  assign irq_vec = nmi_sel ? NMI_VEC : VEC_W'(win_idx);

  assign take    = irq_ack & irq_out;
  assign rise    = {nmi_req & ~nmi_q, irq_req & ~req_q};
  assign ack_hot = take ? (PW'(1) << irq_vec) : '0;
  assign eos_hot = eos_valid ? (PW'(1) << eos_vec) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q    <= '0;
      nmi_q    <= 1'b0;
      pend     <= '0;
      svc      <= '0;
      line_en  <= '0;
      thr      <= '0;
      gie      <= 1'b0;
      auto_off <= 1'b1;
    end else begin
      req_q <= irq_req;
      nmi_q <= nmi_req;
      pend  <= (pend & ~ack_hot) | rise;
      svc   <= (svc & ~eos_hot) | ack_hot;
      if (take && auto_off) gie <= 1'b0;
      if (cfg_we) begin
        case (cfg_sel)
          2'd0: line_en <= cfg_data;
          2'd1: thr <= cfg_data[TH_W-1:0];
          2'd2: begin
            gie      <= cfg_data[0];
            auto_off <= cfg_data[1];
          end
          default: ;
        endcase
      end
    end
  end

  p_gie_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_out && irq_vec != NMI_VEC) |-> gie);

  p_nmi_top_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pend[NUM_LINES] && !svc[NUM_LINES]) |-> (irq_out && irq_vec == NMI_VEC));

  p_line_en_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_out && irq_vec != NMI_VEC) |-> (line_en[irq_vec[IDX_W-1:0]] && pend[irq_vec]));

  p_thresh_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_out && irq_vec != NMI_VEC) |-> (thr <= TH_W'(NUM_LINES - 1) - TH_W'(irq_vec)));

  p_not_in_svc_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> !svc[irq_vec]);

  p_nmi_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_out && irq_vec != NMI_VEC) |-> !svc[NUM_LINES]);

  p_enter_svc_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !eos_valid) |=> svc[$past(irq_vec)]);

  p_auto_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (take && auto_off && !(cfg_we && cfg_sel == 2'd2)) |=> !gie);

  p_idle_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !irq_out && !eos_valid) |=> $stable(svc));

  p_nmi_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_req && !nmi_q) |=> pend[NUM_LINES]);

endmodule

// File: tb/prio_irq_ctrl_tb.sv
`timescale 1ns/1ps
module prio_irq_ctrl_tb;
  localparam int N = 8;

  logic clk = 0;
  logic rst_n = 0;
  logic [N-1:0] irq_req = '0;
  logic nmi_req = 0, cfg_we = 0, irq_ack = 0, eos_valid = 0;
  logic [1:0] cfg_sel = '0;
  logic [N-1:0] cfg_data = '0;
  logic [3:0] eos_vec = '0;
  logic irq_out;
  logic [3:0] irq_vec;

  int total = 0, bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  prio_irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .nmi_req(nmi_req),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
    .irq_ack(irq_ack), .eos_valid(eos_valid), .eos_vec(eos_vec),
    .irq_out(irq_out), .irq_vec(irq_vec)
  );

  bit [N:0] mpend, msvc;
  bit [N-1:0] men, preq;
  bit pnmi, mgie, mauto;
  int mthr;

  function automatic void model_out(output bit o, output int v);
    o = 0; v = 0;
    if (mpend[N] && !msvc[N]) begin o = 1; v = N; return; end
    if (!mgie || msvc[N]) return;
    for (int i = 0; i < N; i++) begin
      if (msvc[i]) return;
      if (mpend[i] && men[i] && (N - 1 - i) >= mthr) begin o = 1; v = i; return; end
    end
  endfunction

  task automatic tick();
    bit eo; int ev;
    bit [N:0] np, ns;
    model_out(eo, ev);
    np = mpend; ns = msvc;
    if (eos_valid && eos_vec <= N) ns[eos_vec] = 0;
    if (irq_ack && eo) begin np[ev] = 0; ns[ev] = 1; end
    for (int i = 0; i < N; i++) if (irq_req[i] && !preq[i]) np[i] = 1;
    if (nmi_req && !pnmi) np[N] = 1;
    @(posedge clk);
    if (!rst_n) begin
      mpend = '0; msvc = '0; men = '0; preq = '0; pnmi = 0;
      mgie = 0; mauto = 1; mthr = 0;
    end else begin
      if (irq_ack && eo && mauto) mgie = 0;
      if (cfg_we) begin
        if (cfg_sel == 2'd0) men = cfg_data;
        else if (cfg_sel == 2'd1) mthr = int'(cfg_data[3:0]);
        else if (cfg_sel == 2'd2) begin mgie = cfg_data[0]; mauto = cfg_data[1]; end
      end
      mpend = np; msvc = ns; preq = irq_req; pnmi = nmi_req;
    end
    @(negedge clk);
    model_out(eo, ev);
    total++;
    if (irq_out !== eo || int'(irq_vec) != ev) begin
      bad++;
      $display("FAIL model R3 got out=%0b vec=%0d exp out=%0b vec=%0d", irq_out, irq_vec, eo, ev);
    end
  endtask

  task automatic chk(string tag, bit o, int v);
    total++;
    if (irq_out !== o || int'(irq_vec) != v) begin
      bad++;
      $display("FAIL %s got out=%0b vec=%0d exp out=%0b vec=%0d", tag, irq_out, irq_vec, o, v);
    end
  endtask

  task automatic wr(logic [1:0] s, logic [N-1:0] d);
    cfg_we = 1; cfg_sel = s; cfg_data = d; tick(); cfg_we = 0;
  endtask
  task automatic ack(); irq_ack = 1; tick(); irq_ack = 0; endtask
  task automatic eos(int v); eos_valid = 1; eos_vec = 4'(v); tick(); eos_valid = 0; endtask
  task automatic up(int i); irq_req[i] = 1; tick(); endtask
  task automatic nmi_up(); nmi_req = 1; tick(); endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog R1 got out=%0b vec=%0d exp out=0 vec=0", irq_out, irq_vec);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    repeat (3) tick();
    rst_n = 1;
    tick();
    chk("R1 reset idle", 0, 0);

    wr(2, 8'h03);
    up(0);
    chk("R1 lines disabled after reset", 0, 0);
    wr(0, 8'hFF);
    chk("R4 pending kept until enabled", 1, 0);
    ack();
    chk("R7 auto disable on entry", 0, 0);
    wr(2, 8'h03);
    eos(0);
    chk("R2 held level not relatched", 0, 0);
    irq_req = '0; tick();

    irq_req[5] = 1; irq_req[2] = 1; tick();
    chk("R3 lowest index wins", 1, 2);
    ack();
    chk("R7 pending cleared and gie off", 0, 0);
    wr(2, 8'h03);
    chk("R8 lower waits for higher in service", 0, 0);
    eos(2);
    chk("R8 end of service releases lower", 1, 5);
    ack();
    wr(2, 8'h01);
    chk("R8 own line in service", 0, 0);
    up(1);
    chk("R8 higher preempts", 1, 1);
    ack();
    chk("R7 auto off keeps gie", 0, 0);
    up(6);
    chk("R8 lower blocked by two in service", 0, 0);
    eos(1);
    chk("R8 still blocked by line 5", 0, 0);
    eos(5);
    chk("R8 lower served after both end", 1, 6);
    ack(); eos(6);
    irq_req = '0; tick();

    ack();
    up(3);
    chk("R10 idle ack ignored", 1, 3);
    ack(); eos(3);
    irq_req = '0; tick();

    wr(1, 8'd8);
    up(0);
    chk("R5 threshold 8 blocks all", 0, 0);
    nmi_up();
    chk("R9 nmi bypasses threshold", 1, 8);
    ack();
    chk("R9 nmi in service", 0, 0);
    nmi_req = 0; tick();
    nmi_up();
    chk("R9 nmi not reentered", 0, 0);
    eos(8);
    chk("R9 deferred nmi edge", 1, 8);
    ack(); eos(8);
    chk("R5 line 0 still blocked", 0, 0);
    wr(1, 8'd4);
    chk("R5 level 7 passes T=4", 1, 0);
    ack(); eos(0);
    up(6);
    chk("R5 level 1 below T=4", 0, 0);
    up(3);
    chk("R5 boundary level 4", 1, 3);
    ack(); eos(3);
    wr(1, 8'd0);
    chk("R5 threshold 0 passes line 6", 1, 6);
    ack(); eos(6);
    irq_req = '0; nmi_req = 0; tick();

    wr(2, 8'h00);
    up(7); up(3); up(5);
    chk("R6 deferred while disabled", 0, 0);
    nmi_up();
    chk("R9 nmi ignores global enable", 1, 8);
    ack(); eos(8);
    wr(2, 8'h01);
    chk("R6 first deferred in order", 1, 3);
    ack(); eos(3);
    chk("R6 second deferred in order", 1, 5);
    ack(); eos(5);
    chk("R6 third deferred in order", 1, 7);
    ack(); eos(7);
    chk("R7 all pending cleared", 0, 0);
    repeat (3) tick();

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule